// File: doc/BRIEF.md
# Line Sensor Readout Controller

This block sits on the host side of a linear photodiode sensor, or of a chain of such sensors that share one video line. It derives the sensor clock from the system clock. It drives the sensor's reset line so that the time reset stays high sets the integration time. After each reset fall it captures one line: every rising edge of the sensor's trigger output latches the current ADC word. Each latched word is tagged with a channel index running across the whole chain and is offered on a valid/ready stream.

The trigger and end-of-scan inputs pass through synchronizers. The reset low time is stretched to cover the video output of every chained channel, so reset can never rise during readout. A line ends when the end-of-scan of the last sensor in the chain has been seen. The line is flagged short if samples are missing, and flagged overflow if a sample arrived while the output was stalled.

Top module: `lsr_ctrl`

## Requirements
- R1: The sensor clock has a period of 2*H system clocks with a 50% duty cycle, where H is the half-period setting clamped into [MIN_HALF, MAX_HALF] (defaults 2 and 1000); it is low after reset.
- R2: The sensor reset output changes only on the system clock edge at which the sensor clock goes from low to high.
- R3: Reset stays high for exactly I sensor clock periods, where I is the integration setting raised to at least 21.
- R4: Reset stays low for exactly 4*T + 24 sensor clock periods, where T = C*S is the chain's channel total. C is the per-sensor channel setting clamped into [1, 128] and S is the sensor count clamped into [1, 4].
- R5: While enable is low, reset stays low once its low phase has completed; the next high phase begins at the first sensor clock rise after enable returns high.
- R6: Between a reset fall and the falling end-of-scan edge of the S-th sensor, each trigger rising edge latches the ADC word and presents it with channel index 0, 1, 2, ... in arrival order across the chain.
- R7: The sample with index 0 carries the start-of-line marker and the sample with index T-1 carries the end-of-line marker; no other sample carries either.
- R8: While valid is high and ready is low, valid stays high and data, index and markers stay unchanged.
- R9: A trigger that arrives while the output is stalled loses its sample but still consumes its index, and it sets the overflow flag. The flag holds until the next reset fall clears it.
- R10: If fewer than T triggers have arrived when the S-th end-of-scan fall is seen, the short-line flag is set and held until the next reset fall. End-of-scan falls of earlier sensors do not set it.
- R11: Triggers after the S-th end-of-scan fall, or beyond the T-th in a line, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permits new integration/readout lines |
| cfg_half | input | 16 | Sensor clock half period in system clocks |
| cfg_integ | input | 16 | Reset high time in sensor clocks |
| cfg_chans | input | 8 | Channels per sensor |
| cfg_sensors | input | 3 | Number of chained sensors |
| sen_clk | output | 1 | Sensor clock |
| sen_reset | output | 1 | Sensor reset (high = integrate) |
| trig_i | input | 1 | Sensor trigger pulse, rising edge = sample point |
| eos_n_i | input | 1 | Sensor end-of-scan, active low |
| adc_i | input | 12 | ADC word of the video line |
| m_valid | output | 1 | Stream sample valid |
| m_ready | input | 1 | Stream sink ready |
| m_data | output | 12 | Captured ADC word |
| m_chan | output | 10 | Channel index across the chain |
| m_sol | output | 1 | Start-of-line marker |
| m_eol | output | 1 | End-of-line marker |
| short_err | output | 1 | Line ended with missing samples |
| ovf_err | output | 1 | Sample lost to backpressure |

## Verification
A wrong divider or phase counter shows up at the reset pin as a high or low width off by whole sensor clocks, visible by the end of the first full line. A reset edge that is not aligned is seen at the same system clock edge as the sensor clock rise. Errors in the capture index or the end-of-scan counter appear at the stream a few system clocks after the trigger or end-of-scan edge that exposes them. They show as a wrong channel tag, a misplaced marker, or a short-line flag set at the wrong sensor. Stalled output that changes or overflow that is not flagged is exposed within the same stalled line.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // clamp an unsigned value into [lo, hi]
  function automatic int unsigned clip(input int unsigned v, input int unsigned lo,
                                       input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/lsr_clkgen.sv
module lsr_clkgen #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] half,
  output logic            sclk_o,
  output logic            rise_now
);
  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap     = (cnt >= half - 1'b1);
  assign rise_now = wrap && !sclk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: rising strobes are never back to back
  assert_rise_spaced_R1: assert property (@(posedge clk) disable iff (rst)
    rise_now |=> !rise_now);
endmodule

// File: rtl/lsr_linegen.sv
module lsr_linegen #(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            rise_now,
  input  logic [CNTW-1:0] hi_t,
  input  logic [CNTW-1:0] lo_t,
  output logic            sreset_o,
  output logic            line_start
);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreset_o   <= 1'b0;
      cnt        <= '1;      // idle: first rise may start a line at once
      line_start <= 1'b0;
    end else begin
      line_start <= 1'b0;
      if (rise_now) begin
        if (sreset_o) begin
          if (cnt >= hi_t - 1'b1) begin
            sreset_o   <= 1'b0;
            cnt        <= '0;
            line_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt >= lo_t - 1'b1) begin
          if (enable) begin
            sreset_o <= 1'b1;
            cnt      <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: reset edges only with a sensor clock rise
  assert_reset_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (sreset_o != $past(sreset_o)) |-> $past(rise_now));
endmodule

// File: rtl/lsr_capture.sv
module lsr_capture #(
  parameter int DATAW = 12,
  parameter int IDXW  = 10,
  parameter int SENSW = 3,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             trig_i,
  input  logic             eos_n_i,
  input  logic [DATAW-1:0] adc_i,
  input  logic [IDXW-1:0]  total,
  input  logic [SENSW-1:0] nsens,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [DATAW-1:0] m_data,
  output logic [IDXW-1:0]  m_chan,
  output logic             m_sol,
  output logic             m_eol,
  output logic             short_err,
  output logic             ovf_err
);
  logic [SYNC:0]    trig_sh, eos_sh;
  logic             trig_rise, eos_fall, active, take;
  logic [IDXW-1:0]  idx;
  logic [SENSW-1:0] eos_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_sh <= '0;
      eos_sh  <= '1;
    end else begin
      trig_sh <= {trig_sh[SYNC-1:0], trig_i};
      eos_sh  <= {eos_sh[SYNC-1:0], eos_n_i};
    end
  end

  assign trig_rise = trig_sh[SYNC-1] && !trig_sh[SYNC];
  assign eos_fall  = !eos_sh[SYNC-1] && eos_sh[SYNC];
  assign take      = active && trig_rise && (idx < total);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid   <= 1'b0;
      m_data    <= '0;
      m_chan    <= '0;
      m_sol     <= 1'b0;
      m_eol     <= 1'b0;
      short_err <= 1'b0;
      ovf_err   <= 1'b0;
      active    <= 1'b0;
      idx       <= '0;
      eos_cnt   <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (line_start) begin
        active    <= 1'b1;
        idx       <= '0;
        eos_cnt   <= '0;
        short_err <= 1'b0;
        ovf_err   <= 1'b0;
      end else if (active) begin
        if (take) begin
          idx <= idx + 1'b1;
          if (m_valid && !m_ready) begin
            ovf_err <= 1'b1;
          end else begin
            m_valid <= 1'b1;
            m_data  <= adc_i;
            m_chan  <= idx;
            m_sol   <= (idx == '0);
            m_eol   <= (idx == total - 1'b1);
          end
        end
        if (eos_fall) begin
          if (eos_cnt == nsens - 1'b1) begin
            active <= 1'b0;
            if (idx < total) short_err <= 1'b1;
          end else begin
            eos_cnt <= eos_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R8: stalled output holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));
  // R9: overflow only appears while the output was stalled
  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(m_valid && !m_ready));
  // R7: start marker only on index zero
  assert_sol_first_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_sol) |-> (m_chan == '0));
endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl #(
  parameter int DIVW      = 16,
  parameter int MIN_HALF  = 2,
  parameter int MAX_HALF  = 1000,
  parameter int INTW      = 16,
  parameter int MIN_INTEG = 21,
  parameter int CHCFGW    = 8,
  parameter int MAX_CHAN  = 128,
  parameter int SENSW     = 3,
  parameter int MAX_SENS  = 4,
  parameter int DATAW     = 12,
  parameter int LOW_PAD   = 24,
  parameter int SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIVW-1:0]   cfg_half,
  input  logic [INTW-1:0]   cfg_integ,
  input  logic [CHCFGW-1:0] cfg_chans,
  input  logic [SENSW-1:0]  cfg_sensors,
  output logic              sen_clk,
  output logic              sen_reset,
  input  logic              trig_i,
  input  logic              eos_n_i,
  input  logic [DATAW-1:0]  adc_i,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATAW-1:0]  m_data,
  output logic [$clog2(MAX_CHAN*MAX_SENS+1)-1:0] m_chan,
  output logic              m_sol,
  output logic              m_eol,
  output logic              short_err,
  output logic              ovf_err
);
  import lsr_pkg::*;

  localparam int IDXW = $clog2(MAX_CHAN*MAX_SENS+1);
  localparam int CNTW = (INTW > IDXW + 3) ? INTW : IDXW + 3;

  logic [DIVW-1:0]  half_c;
  logic [IDXW-1:0]  chans_c, total;
  logic [SENSW-1:0] sens_c;
  logic [CNTW-1:0]  hi_t, lo_t;
  logic             rise_now, line_start;

  always_comb begin
    half_c  = DIVW'(clip(int'(cfg_half), MIN_HALF, MAX_HALF));
    chans_c = IDXW'(clip(int'(cfg_chans), 1, MAX_CHAN));
    sens_c  = SENSW'(clip(int'(cfg_sensors), 1, MAX_SENS));
    total   = IDXW'(int'(chans_c) * int'(sens_c));
    hi_t    = CNTW'(clip(int'(cfg_integ), MIN_INTEG, (1 << INTW) - 1));
    lo_t    = CNTW'(4 * int'(total) + LOW_PAD);
  end

  lsr_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .half(half_c), .sclk_o(sen_clk), .rise_now(rise_now));

  lsr_linegen #(.CNTW(CNTW)) u_line (
    .clk(clk), .rst(rst), .enable(enable), .rise_now(rise_now), .hi_t(hi_t),
    .lo_t(lo_t), .sreset_o(sen_reset), .line_start(line_start));

  lsr_capture #(.DATAW(DATAW), .IDXW(IDXW), .SENSW(SENSW), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst(rst), .line_start(line_start), .trig_i(trig_i),
    .eos_n_i(eos_n_i), .adc_i(adc_i), .total(total), .nsens(sens_c),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .m_chan(m_chan),
    .m_sol(m_sol), .m_eol(m_eol), .short_err(short_err), .ovf_err(ovf_err));
endmodule

// File: tb/test_lsr_ctrl.sv
module test_lsr_ctrl;
  logic clk = 1'b0, rst = 1'b1, enable = 1'b1;
  logic [15:0] cfg_half = 16'd2, cfg_integ = 16'd21;
  logic [7:0]  cfg_chans = 8'd4;
  logic [2:0]  cfg_sensors = 3'd2;
  logic sen_clk, sen_reset, trig_i = 1'b0, eos_n_i = 1'b1, m_ready = 1'b1;
  logic [11:0] adc_i = '0, m_data;
  logic [9:0]  m_chan;
  logic m_valid, m_sol, m_eol, short_err, ovf_err;
  int n_chk = 0, n_bad = 0, r2_bad = 0, got_n = 0;
  logic [11:0] got_data [0:15];
  logic [9:0]  got_chan [0:15];
  logic        got_sol [0:15], got_eol [0:15];
  logic sr_prev = 1'b0, sc_prev = 1'b0;

  always #2 clk = ~clk;

  lsr_ctrl i_lsr_ctrl (.clk(clk), .rst(rst), .enable(enable), .cfg_half(cfg_half),
    .cfg_integ(cfg_integ), .cfg_chans(cfg_chans), .cfg_sensors(cfg_sensors),
    .sen_clk(sen_clk), .sen_reset(sen_reset), .trig_i(trig_i), .eos_n_i(eos_n_i),
    .adc_i(adc_i), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_chan(m_chan), .m_sol(m_sol), .m_eol(m_eol), .short_err(short_err),
    .ovf_err(ovf_err));

  // stream collector and R2 edge monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid && m_ready && got_n < 16) begin
        got_data[got_n] = m_data; got_chan[got_n] = m_chan;
        got_sol[got_n] = m_sol; got_eol[got_n] = m_eol;
        got_n = got_n + 1;
      end
      if (sen_reset != sr_prev && !(sen_clk && !sc_prev)) r2_bad = r2_bad + 1;
    end
    sr_prev = sen_reset; sc_prev = sen_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    @(negedge clk); while (!(sen_reset && !sr_prev)) @(negedge clk);
  endtask
  task automatic wait_fall();
    @(negedge clk); while (!(!sen_reset && sr_prev)) @(negedge clk);
  endtask

  task automatic pulse_trig(input logic [11:0] d);
    adc_i = d; trig_i = 1'b1;
    repeat (2) @(negedge clk);
    trig_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask
  task automatic pulse_eos();
    eos_n_i = 1'b0;
    repeat (2) @(negedge clk);
    eos_n_i = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // set config in a high phase, then start a fresh line
  task automatic new_line(input int ch, input int ns);
    wait_rise();
    cfg_chans = 8'(ch); cfg_sensors = 3'(ns);
    wait_fall();
    got_n = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 clk low in reset", int'(sen_clk), 0);
    check("R2 reset low in reset", int'(sen_reset), 0);
    check("R6 no valid in reset", int'(m_valid), 0);
    check("R9/R10 flags clear", int'(ovf_err) + int'(short_err), 0);
    rst = 1'b0;
  endtask

  task automatic t_clock(input int h, input int exp_half);
    int n;
    cfg_half = 16'(h);
    repeat (4) @(posedge sen_clk);
    @(negedge clk); n = 0;
    while (sen_clk) begin n++; @(negedge clk); end
    check("R1 low part", 0, 0);
    begin
      int lo = 0;
      while (!sen_clk) begin lo++; @(negedge clk); end
      check("R1 high width", n, exp_half);
      check("R1 low width", lo, exp_half);
    end
  endtask

  task automatic t_integ(input int integ, input int exp_sclk);
    int n;
    cfg_half = 16'd3;
    wait_rise(); cfg_integ = 16'(integ);
    wait_rise(); n = 0;
    while (sen_reset) begin n++; @(negedge clk); end
    check("R3 reset high width", n, exp_sclk * 6);
  endtask

  task automatic t_low();
    int n;
    cfg_half = 16'd2; cfg_integ = 16'd21;
    new_line(4, 2);
    n = 1;
    @(negedge clk);
    while (!sen_reset) begin n++; @(negedge clk); end
    check("R4 reset low width", n, (4 * 8 + 24) * 4);
  endtask

  task automatic t_line();
    new_line(4, 2);
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) pulse_trig(12'(12'h100 + s * 16 + c));
      pulse_eos();
    end
    check("R6 sample count", got_n, 8);
    for (int k = 0; k < 8; k++) begin
      check("R6 data", int'(got_data[k]), 12'h100 + (k / 4) * 16 + (k % 4));
      check("R6 index", int'(got_chan[k]), k);
      check("R7 start marker", int'(got_sol[k]), (k == 0) ? 1 : 0);
      check("R7 end marker", int'(got_eol[k]), (k == 7) ? 1 : 0);
    end
    check("R10 no short on full line", int'(short_err), 0);
    check("R9 no overflow", int'(ovf_err), 0);
  endtask

  task automatic t_clamp();
    new_line(0, 0);
    pulse_trig(12'h3A5);
    pulse_eos();
    check("R4 clamp count", got_n, 1);
    check("R7 single sample both markers",
          int'(got_sol[0]) + int'(got_eol[0]), 2);
    check("R4 clamp index", int'(got_chan[0]), 0);
  endtask

  task automatic t_backpressure();
    new_line(4, 1);
    m_ready = 1'b0;
    pulse_trig(12'h011); pulse_trig(12'h022); pulse_trig(12'h033);
    check("R8 valid held", int'(m_valid), 1);
    check("R8 data held", int'(m_data), 12'h011);
    check("R9 overflow set", int'(ovf_err), 1);
    m_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    pulse_trig(12'h044);
    pulse_eos();
    check("R9 delivered count", got_n, 2);
    check("R9 lost index consumed", int'(got_chan[1]), 3);
    check("R10 no short after drops", int'(short_err), 0);
    new_line(4, 1);
    repeat (3) @(negedge clk);
    check("R9 overflow cleared", int'(ovf_err), 0);
  endtask

  task automatic t_short();
    new_line(4, 2);
    for (int c = 0; c < 4; c++) pulse_trig(12'(c));
    pulse_eos();
    check("R10 earlier eos ignored", int'(short_err), 0);
    for (int c = 0; c < 3; c++) pulse_trig(12'(c));
    pulse_eos();
    check("R10 short flagged", int'(short_err), 1);
    pulse_trig(12'h7FF);
    check("R11 late trigger ignored", got_n, 7);
    check("R11 no valid after end", int'(m_valid), 0);
    new_line(4, 2);
    repeat (3) @(negedge clk);
    check("R10 short cleared", int'(short_err), 0);
  endtask

  task automatic t_extra();
    new_line(2, 1);
    pulse_trig(12'h1); pulse_trig(12'h2); pulse_trig(12'h3);
    check("R11 beyond total ignored", got_n, 2);
    pulse_eos();
  endtask

  task automatic t_enable();
    int n;
    wait_rise(); enable = 1'b0;
    wait_fall();
    n = 0;
    repeat (600) begin @(negedge clk); n += int'(sen_reset); end
    check("R5 held low while disabled", n, 0);
    enable = 1'b1;
    n = 0;
    repeat (20) begin @(negedge clk); n += int'(sen_reset); end
    check("R5 resumes when enabled", int'(n > 0), 1);
  endtask

  initial begin
    #600000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clock(3, 3);
    t_clock(0, 2);
    t_integ(30, 30);
    t_integ(5, 21);
    t_low();
    t_line();
    t_clamp();
    t_backpressure();
    t_short();
    t_extra();
    t_enable();
    check("R2 reset edges on sensor clock rise", r2_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule